// File: doc/BRIEF.md
# Quad SPI flash line fetcher

This block reads one complete cache line from an external quad-I/O serial flash and hands it over as a single wide bus. A requester places a byte address on `rd_addr` and pulses `rd_req` for one cycle. The block clears the low address bits to reach the line boundary. It then lowers the chip select and shifts out the quad-read command on one data line, followed by the 24-bit address in nibbles on all four lines. It releases the lines and gathers the line bytes, two nibbles per byte. When the last nibble is in, it returns a one-cycle `done` pulse with the whole line on `line`.

The serial clock runs at half the system clock. Each flash clock spans two system clocks: low in the first and high in the second. A fill therefore costs 28 clocks of fixed overhead plus 4 clocks per byte. After every system reset the block first runs a flash software-reset phase. For 2·(RESET_CYCLES+1) clocks it holds the chip select low, toggles the serial clock and drives all four data lines high. It accepts no request until that phase has ended.

Top module: `qspi_line_fetch`

## Requirements
- R1: While reset is asserted, and from the first clock edge after release for exactly 2·(RESET_CYCLES+1) cycles, `ce_n` is 0, `dout_en_n` is 4'b0000, `dout` is 4'b1111 and `done` is 0. After that, `ce_n` is 1.
- R2: A read strobe during the software-reset phase is ignored: `ce_n` returns high at the normal time and no fill or `done` follows.
- R3: During the first 8 serial clocks of a fill, `dout[0]` carries the command byte 0xEB, most significant bit first, and `dout_en_n` is 4'b1110 (only line 0 driven; an enable of 0 means driven).
- R4: During the next 6 serial clocks, `dout` carries the 24-bit address, most significant nibble first, with its low log2(LINE_SIZE) bits forced to 0, and `dout_en_n` is 4'b0000.
- R5: During the data phase, `dout_en_n` is 4'b1111. The block samples `din` at the system edge that ends each high half of `sck`. Outside a fill or reset phase, `dout_en_n` is also 4'b1111.
- R6: Received bytes are packed little-endian: the first byte read lands in `line[7:0]`. Within each byte the upper nibble arrives first.
- R7: `done` is high for exactly one cycle, 28+4·LINE_SIZE clock edges after the edge that sampled `rd_req`, with `ce_n` already high in that cycle and `line` valid.
- R8: `ce_n` is low for exactly 28+4·LINE_SIZE cycles per fill and stays high between fills.
- R9: A read strobe during a fill, including on its last cycle, is ignored: one `done` only, and no new fill starts.
- R10: `sck` is 0 whenever `ce_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | One-cycle line read strobe |
| rd_addr | input | 24 | Byte address; low bits are cleared to the line boundary |
| done | output | 1 | One-cycle pulse when the line is captured |
| line | output | 8*LINE_SIZE | Fetched line, byte 0 in bits [7:0] |
| sck | output | 1 | Flash serial clock, half the system clock rate |
| ce_n | output | 1 | Flash chip select, active low |
| dout | output | 4 | Data to the flash |
| dout_en_n | output | 4 | Per-line output enable, 0 = driven |
| din | input | 4 | Data from the flash |

## Verification
The embedded assertions check, on every cycle, a set of local rules:
- `done` is a single-cycle pulse and coincides with a high chip select.
- The output-enable pattern is one of the three legal codes.
- `sck` rests low while the chip select is high.
- The latched address cannot change during a fill.
- No fill starts straight out of the reset phase.

The bench's flash model and scenarios are needed for the rest:
- the serial command and address contents,
- the exact fill latency and chip-select width,
- the byte and nibble ordering in the returned line,
- the length of the reset phase.

Ignored strobes are checked there too: the bench places them early in the reset phase, mid-fill and on the final fill cycle.

// File: rtl/qlf_pkg.sv
// Package: shared phase type and constants of the quad SPI line fetcher.
package qlf_pkg;
    // Controller phase: flash software reset, waiting for a request, or filling a line.
    typedef enum logic [1:0] {
        PH_RESET = 2'd0,
        PH_IDLE  = 2'd1,
        PH_FILL  = 2'd2
    } qlf_phase_e;

    // Quad-I/O read command, sent serially on line 0.
    localparam logic [7:0] CMD_QREAD = 8'hEB;
    // System-clock offsets inside a fill: command ends, address ends.
    localparam int CMD_CLKS  = 16;
    localparam int HDR_CLKS  = 28;
endpackage

// File: rtl/qlf_sequencer.sv
// Sequencer: owns the phase and system-clock counter of the fetcher.
// Runs the software-reset phase after reset, latches a line-aligned address
// on an accepted strobe, and raises done after the fill's final cycle.
// Assumes rd_req is sampled only in the idle phase.
module qlf_sequencer
    import qlf_pkg::*;
#(
    parameter int LINE_SIZE    = 32,
    parameter int RESET_CYCLES = 999,
    parameter int CW           = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [23:0]   rd_addr,
    output qlf_phase_e    ph,
    output logic [CW-1:0] cnt,
    output logic [23:0]   addr_q,
    output logic          take,
    output logic          take_hi,
    output logic          done
);
    localparam int RST_LEN  = 2 * (RESET_CYCLES + 1);
    localparam int FILL_LEN = HDR_CLKS + 4 * LINE_SIZE;
    localparam int OW       = $clog2(LINE_SIZE);
    localparam logic [23:0]   ALIGN_MASK = ~24'((1 << OW) - 1);
    localparam logic [CW-1:0] RST_END    = CW'(RST_LEN);
    localparam logic [CW-1:0] FILL_LAST  = CW'(FILL_LEN - 1);
    localparam logic [CW-1:0] DATA_FIRST = CW'(HDR_CLKS);

    // Phase, counter, address latch and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_RESET;
            cnt    <= '0;
            addr_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_RESET: begin
                    if (cnt == RST_END) begin
                        ph  <= PH_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_IDLE: begin
                    if (rd_req) begin
                        ph     <= PH_FILL;
                        cnt    <= '0;
                        addr_q <= rd_addr & ALIGN_MASK;
                    end
                end
                default: begin
                    if (cnt == FILL_LAST) begin
                        ph   <= PH_IDLE;
                        cnt  <= '0;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Capture strobe at the end of every sck-high half of the data phase.
    always_comb begin
        take    = (ph == PH_FILL) && (cnt >= DATA_FIRST) && cnt[0];
        take_hi = !cnt[1];
    end

    // R7: done lasts a single cycle.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: a strobe during a fill leaves the latched address untouched.
    p_fill_ignores_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_FILL && rd_req) |=> $stable(addr_q));
    // R2: the reset phase never hands over directly to a fill.
    p_reset_no_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_RESET) |=> (ph != PH_FILL));
endmodule

// File: rtl/qlf_io_drive.sv
// IO driver: decodes phase and counter into the flash pins.
// Purely combinational; sck is high in the odd system-clock half of each
// flash clock. Assumes the counter restarts at zero on each phase entry.
module qlf_io_drive
    import qlf_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  qlf_phase_e    ph,
    input  logic [CW-1:0] cnt,
    input  logic [23:0]   addr_q,
    output logic          sck,
    output logic          ce_n,
    output logic [3:0]    dout,
    output logic [3:0]    dout_en_n
);
    localparam logic [CW-1:0] CMD_END = CW'(CMD_CLKS);
    localparam logic [CW-1:0] HDR_END = CW'(HDR_CLKS);

    logic [CW-1:0] bit_idx;
    logic [CW-1:0] nib_idx;

    // Serial clock and chip select from the phase.
    always_comb begin
        ce_n = (ph == PH_IDLE);
        sck  = (ph != PH_IDLE) && cnt[0];
    end

    // Data lines and enables for each part of a transaction.
    always_comb begin
        bit_idx   = cnt >> 1;
        nib_idx   = (cnt - CMD_END) >> 1;
        dout      = 4'h0;
        dout_en_n = 4'b1111;
        case (ph)
            PH_RESET: begin
                dout      = 4'b1111;
                dout_en_n = 4'b0000;
            end
            PH_FILL: begin
                if (cnt < CMD_END) begin
                    dout      = {3'b000, 1'(CMD_QREAD >> (CW'(7) - bit_idx))};
                    dout_en_n = 4'b1110;
                end else if (cnt < HDR_END) begin
                    dout      = 4'(addr_q >> (CW'(20) - (nib_idx << 2)));
                    dout_en_n = 4'b0000;
                end
            end
            default: ;
        endcase
    end

    // R5: enables take only the three legal codes.
    p_oe_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en_n == 4'b1111) || (dout_en_n == 4'b1110) || (dout_en_n == 4'b0000));
    // R10: the serial clock rests low with the chip deselected.
    p_sck_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !sck);
endmodule

// File: rtl/qlf_line_capture.sv
// Line capture: assembles nibbles into bytes and shifts bytes into the line.
// The upper nibble is held, and the byte is pushed in at the top when the
// lower nibble arrives, so the first byte ends in bits [7:0].
// Assumes LINE_SIZE >= 2.
module qlf_line_capture #(
    parameter int LINE_SIZE = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take,
    input  logic                   take_hi,
    input  logic [3:0]             din,
    output logic [8*LINE_SIZE-1:0] line
);
    localparam int LW = 8 * LINE_SIZE;

    logic [3:0] hi_nib;

    // Hold the upper nibble, then shift the whole byte into the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_nib <= '0;
            line   <= '0;
        end else if (take) begin
            if (take_hi) hi_nib <= din;
            else         line   <= {hi_nib, din, line[LW-1:8]};
        end
    end
endmodule

// File: rtl/qspi_line_fetch.sv
// Top: quad SPI flash line fetcher. Connects the sequencer, the pin driver
// and the line capture. Assumes LINE_SIZE is a power of two, at least 2.
module qspi_line_fetch
    import qlf_pkg::*;
#(
    parameter int LINE_SIZE    = 32,
    parameter int RESET_CYCLES = 999
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_req,
    input  logic [23:0]            rd_addr,
    output logic                   done,
    output logic [8*LINE_SIZE-1:0] line,
    output logic                   sck,
    output logic                   ce_n,
    output logic [3:0]             dout,
    output logic [3:0]             dout_en_n,
    input  logic [3:0]             din
);
    localparam int RST_LEN  = 2 * (RESET_CYCLES + 1);
    localparam int FILL_LEN = HDR_CLKS + 4 * LINE_SIZE;
    localparam int MAXV     = (RST_LEN > FILL_LEN) ? RST_LEN : FILL_LEN;
    localparam int CW       = $clog2(MAXV + 1);

    qlf_phase_e    ph;
    logic [CW-1:0] cnt;
    logic [23:0]   addr_q;
    logic          take;
    logic          take_hi;

    qlf_sequencer #(
        .LINE_SIZE(LINE_SIZE), .RESET_CYCLES(RESET_CYCLES), .CW(CW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .ph(ph), .cnt(cnt), .addr_q(addr_q), .take(take), .take_hi(take_hi),
        .done(done)
    );

    qlf_io_drive #(.CW(CW)) u_io (
        .clk(clk), .rst_n(rst_n), .ph(ph), .cnt(cnt), .addr_q(addr_q),
        .sck(sck), .ce_n(ce_n), .dout(dout), .dout_en_n(dout_en_n)
    );

    qlf_line_capture #(.LINE_SIZE(LINE_SIZE)) u_cap (
        .clk(clk), .rst_n(rst_n), .take(take), .take_hi(take_hi),
        .din(din), .line(line)
    );

    // R7: done always coincides with a deselected flash.
    p_done_ce_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ce_n);
endmodule

// File: tb/qspi_line_fetch_test.sv
module qspi_line_fetch_test;
    localparam int LS  = 4;
    localparam int RC  = 3;
    localparam int L   = 28 + 4 * LS;
    localparam int RSL = 2 * (RC + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req = 1'b0;
    logic [23:0] rd_addr = '0;
    logic done, sck, ce_n;
    logic [8*LS-1:0] line;
    logic [3:0] dout, dout_en_n;
    logic [3:0] din = 4'h0;

    int tests = 0;
    int fails = 0;
    bit fill_mode = 1'b0;
    bit finished = 1'b0;
    int rises = 0;
    int oe_err = 0;
    int sck_err = 0;
    logic [7:0]  cmd_c = '0;
    logic [23:0] adr_c = '0;

    qspi_line_fetch #(.LINE_SIZE(LS), .RESET_CYCLES(RC)) uut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .done(done), .line(line), .sck(sck), .ce_n(ce_n), .dout(dout),
        .dout_en_n(dout_en_n), .din(din)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return 8'(a[7:0] * 8'd37) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h6C;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Flash model: collect command and address, check enables.
    always @(posedge sck) begin
        if (fill_mode) begin
            if (rises < 8) begin
                cmd_c = {cmd_c[6:0], dout[0]};
                if (dout_en_n != 4'b1110) oe_err++;
            end else if (rises < 14) begin
                adr_c = {adr_c[19:0], dout};
                if (dout_en_n != 4'b0000) oe_err++;
            end else if (dout_en_n != 4'b1111) begin
                oe_err++;
            end
            rises++;
        end
    end

    // Flash model: present the next nibble after each falling sck.
    always @(negedge sck) begin
        if (fill_mode && rises >= 14) begin
            int m;
            logic [7:0] b;
            m = rises - 14;
            b = fbyte(adr_c + 24'(m / 2));
            din = m[0] ? b[3:0] : b[7:4];
        end
    end

    // R10 monitor: sck must rest low while deselected.
    always @(negedge clk) if (rst_n && ce_n && sck) sck_err++;

    task automatic do_fill(input logic [23:0] a, input bit inject);
        logic [23:0] base;
        logic [8*LS-1:0] exp_line, got;
        int low, dcount, dat;
        bit cehi;
        base = a & ~24'(LS - 1);
        for (int k = 0; k < LS; k++) exp_line[8*k +: 8] = fbyte(base + 24'(k));
        low = 0; dcount = 0; dat = -1; cehi = 1'b0; got = '0;
        rises = 0; oe_err = 0; cmd_c = '0; adr_c = '0;
        @(negedge clk); rd_req = 1'b1; rd_addr = a;
        @(posedge clk);
        for (int n = 0; n <= L + 6; n++) begin
            @(negedge clk);
            if (n == 0) rd_req = 1'b0;
            if (inject && (n == 10 || n == L - 1)) begin rd_req = 1'b1; rd_addr = ~a; end
            if (inject && (n == 11 || n == L)) rd_req = 1'b0;
            if (!ce_n) low++;
            if (done) begin dcount++; dat = n; got = line; cehi = ce_n; end
        end
        chk(cmd_c == 8'hEB, "R3 command byte", 64'(cmd_c), 64'hEB);
        chk(adr_c == base, "R4 aligned address", 64'(adr_c), 64'(base));
        chk(oe_err == 0, "R5 enable pattern errors", 64'(oe_err), 0);
        chk(dat == L, "R7 done latency", 64'(dat), 64'(L));
        chk(dcount == 1, "R9 one done per fill", 64'(dcount), 1);
        chk(cehi, "R7 ce_n high at done", 64'(cehi), 1);
        chk(low == L, "R8 ce_n low width", 64'(low), 64'(L));
        chk(got == exp_line, "R6 line packing", 64'(got), 64'(exp_line));
    endtask

    initial begin
        int low;
        int bad;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && ce_n == 1'b0, "R1 reset done/ce_n", {62'd0, done, ce_n}, 0);
        chk(dout_en_n == 4'b0000 && dout == 4'b1111, "R1 reset pins",
            {56'd0, dout_en_n, dout}, 64'h0F);
        rst_n = 1'b1;
        low = 0; bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (k == 2) begin rd_req = 1'b1; rd_addr = 24'h000040; end
            if (k == 3) rd_req = 1'b0;
            if (ce_n) break;
            low++;
            if (dout_en_n != 4'b0000 || dout != 4'b1111 || done) bad++;
        end
        chk(low == RSL, "R1 reset phase length", 64'(low), 64'(RSL));
        chk(bad == 0, "R1 reset phase pins", 64'(bad), 0);
        chk(dout_en_n == 4'b1111, "R5 idle released", 64'(dout_en_n), 64'hF);
        bad = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (!ce_n || done) bad++;
        end
        chk(bad == 0, "R2 strobe in reset ignored", 64'(bad), 0);
        fill_mode = 1'b1;
        do_fill(24'h000000, 1'b0);
        do_fill(24'hFFFFFF, 1'b0);
        do_fill(24'h000013, 1'b1);
        for (int i = 1; i < 16; i++) do_fill(24'(i * 24'h111111) ^ 24'(i), (i % 3) == 0);
        chk(sck_err == 0, "R10 sck idle low", 64'(sck_err), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule